// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block lets a 16-bit CPU reach a 1 MB external SRAM through two fixed 8 KB windows in its address space. The lower window (0xA000 to 0xBFFF) always lands in the lower 512 KB half of the SRAM and the upper window (0xC000 to 0xDFFF) always lands in the upper half. Inside its half, each window shows one of 64 frames of 8 KB. A 6-bit bank latch picks the frame, and the CPU writes that latch through an I/O address.

The block decodes the CPU address together with its read/write and valid-memory-access qualifiers. It owns the two bank latches and returns their contents on I/O reads. It drives the 20-bit physical SRAM address and the active-low SRAM chip enable. It also raises two select flags that the CPU read-data multiplexer uses: one for SRAM read data and one for bank-register read data. The latches update on the clock edge that ends a qualified write cycle. The address path and the select flags are combinational from the current CPU address and the latch contents.

Top module: `bwm_top`

## Requirements
- R1: After a synchronous active-low reset, both bank latches hold 0, so an I/O read of either latch returns 0x00.
- R2: A valid access in 0xA000..0xBFFF drives sram_addr = {1'b0, lower latch[5:0], cpu_addr[12:0]}: bit 19 is 0, bits 18:13 are the latch and bits 12:0 are the offset.
- R3: A valid access in 0xC000..0xDFFF drives sram_addr = {1'b1, upper latch[5:0], cpu_addr[12:0]}.
- R4: A cycle with cpu_vma=1, cpu_rnw=0 (write) and cpu_addr=0xFC30 loads cpu_wdata[5:0] into the lower latch, and at 0xFC31 into the upper latch. The new value drives sram_addr from the following cycle.
- R5: A cycle with cpu_vma=1, cpu_rnw=1 and cpu_addr=0xFC30 or 0xFC31 raises reg_hit and returns {2'b00, latch} on reg_rdata. In every other cycle reg_hit is 0 and reg_rdata is 0x00.
- R6: sram_ce_n is 0 exactly when cpu_vma=1 and cpu_addr is in 0xA000..0xDFFF, for reads and writes alike. It is 1 for every other address and whenever cpu_vma=0.
- R7: sram_hit is 1 only for a valid read (cpu_rnw=1) inside a window. Whenever sram_ce_n is 1, sram_addr is all zeros.
- R8: A latch keeps its value through any cycle that is not a qualified write to its own address: cpu_vma=0, a read, or a neighbouring address such as 0xFC2F, 0xFC32 or the other latch.
- R9: Every one of the 128 frames (64 per window) maps to a distinct physical region, so a ramp pattern written into each frame reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_vma | input | 1 | Valid memory access qualifier |
| cpu_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Bank latch read-back data, zero-extended |
| reg_hit | output | 1 | Read-data multiplexer select for the bank latches |
| sram_addr | output | 20 | Physical SRAM address |
| sram_ce_n | output | 1 | Active-low external SRAM chip enable |
| sram_hit | output | 1 | Read-data multiplexer select for SRAM data |

## Verification
The assertions assume that cpu_addr, cpu_rnw, cpu_vma and cpu_wdata are known and settled when each rising edge arrives once reset is released. They also assume that each CPU cycle holds its address for the whole clock period, so the decoded write strobe on one edge reflects a single access. The bench meets these conditions by changing every input only on the falling edge, reading the combinational outputs a short time later, and holding the inputs fixed until the next falling edge. Reset is asserted from time zero, so the inputs are never unknown at a sampled edge after release.

// File: rtl/bwm_pkg.sv
// Package: shared constants for the banked window mapper.
// Assumes a CPU address of 16 bits split into a page field and an 8 KB offset.
package bwm_pkg;
    localparam int              CPU_AW    = 16;       // CPU address width
    localparam int              DATA_W    = 8;        // CPU data width
    localparam int              BANK_W    = 6;        // bank latch width (64 frames)
    localparam int              OFS_W     = 13;       // offset bits inside an 8 KB window
    localparam int              NUM_WIN   = 2;        // number of windows
    localparam logic [15:0]     IO_BASE   = 16'hFC30; // first bank latch I/O address
    localparam logic [2:0]      WIN_PAGE0 = 3'd5;     // page of the first window (0xA000)
endpackage

// File: rtl/bwm_decode.sv
// Module: bwm_decode
// Decodes the CPU address into per-window hits, a binary window index and
// per-latch I/O read and write strobes. Purely combinational.
// Assumes windows occupy consecutive pages starting at WIN_PAGE0 and latches
// occupy consecutive I/O addresses starting at IO_BASE.
module bwm_decode #(
    parameter int                    CPU_AW    = 16,
    parameter int                    OFS_W     = 13,
    parameter int                    NUM_WIN   = 2,
    parameter int                    SEL_W     = 1,
    parameter logic [CPU_AW-1:0]     IO_BASE   = 16'hFC30,
    parameter logic [CPU_AW-OFS_W-1:0] WIN_PAGE0 = 3'd5
) (
    input  logic [CPU_AW-1:0]  addr,
    input  logic               rnw,
    input  logic               vma,
    output logic [NUM_WIN-1:0] win_hit,
    output logic [SEL_W-1:0]   win_idx,
    output logic [NUM_WIN-1:0] io_wr,
    output logic [NUM_WIN-1:0] io_rd
);
    localparam int PAGE_W = CPU_AW - OFS_W;

    logic [PAGE_W-1:0] page;
    assign page = addr[CPU_AW-1:OFS_W];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [PAGE_W-1:0] PG   = WIN_PAGE0 + PAGE_W'(i);
        localparam logic [CPU_AW-1:0] IO_A = IO_BASE + CPU_AW'(i);
        // Window i hit: qualified access in its page
        assign win_hit[i] = vma && (page == PG);
        // Latch i write strobe: qualified write at its I/O address
        assign io_wr[i]   = vma && !rnw && (addr == IO_A);
        // Latch i read strobe: qualified read at its I/O address
        assign io_rd[i]   = vma && rnw && (addr == IO_A);
    end

    // Encode the one-hot window hit into a binary index
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) win_idx = SEL_W'(i);
        end
    end
endmodule

// File: rtl/bwm_bank_latch.sv
// Module: bwm_bank_latch
// One writable bank register. Loads the low BANK_W bits of the write data on a
// write strobe and clears on synchronous active-low reset.
// Assumes DATA_W >= BANK_W.
module bwm_bank_latch #(
    parameter int BANK_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] q
);
    // Hold or load the frame number
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata[BANK_W-1:0];
    end
endmodule

// File: rtl/bwm_compose.sv
// Module: bwm_compose
// Builds the physical SRAM address from the window index, that window's bank
// latch and the CPU offset, and drives the chip enable and SRAM read select.
// Assumes at most one window hit at a time (windows do not overlap).
module bwm_compose #(
    parameter int NUM_WIN = 2,
    parameter int SEL_W   = 1,
    parameter int BANK_W  = 6,
    parameter int OFS_W   = 13,
    parameter int PHYS_W  = 20
) (
    input  logic [NUM_WIN-1:0]        win_hit,
    input  logic [SEL_W-1:0]          win_idx,
    input  logic [NUM_WIN*BANK_W-1:0] bank_flat,
    input  logic [OFS_W-1:0]          offset,
    input  logic                      rnw,
    output logic [PHYS_W-1:0]         sram_addr,
    output logic                      sram_ce_n,
    output logic                      sram_hit
);
    logic              any_hit;
    logic [BANK_W-1:0] sel_bank;

    assign any_hit = |win_hit;

    // Pick the bank latch belonging to the hit window
    always_comb begin
        sel_bank = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_idx == SEL_W'(i)) sel_bank = bank_flat[i*BANK_W +: BANK_W];
        end
    end

    // Concatenate half select, frame and offset; zero when not selected
    always_comb begin
        if (any_hit) sram_addr = {win_idx, sel_bank, offset};
        else         sram_addr = '0;
    end

    // Chip enable and read-mux select
    assign sram_ce_n = !any_hit;
    assign sram_hit  = any_hit && rnw;
endmodule

// File: rtl/bwm_readback.sv
// Module: bwm_readback
// Returns the addressed bank latch, zero-extended, on a qualified I/O read and
// zero otherwise. Assumes at most one read strobe is high.
module bwm_readback #(
    parameter int NUM_WIN = 2,
    parameter int BANK_W  = 6,
    parameter int DATA_W  = 8
) (
    input  logic [NUM_WIN-1:0]        io_rd,
    input  logic [NUM_WIN*BANK_W-1:0] bank_flat,
    output logic [DATA_W-1:0]         rdata,
    output logic                      hit
);
    // OR together the strobed latches, upper bits zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (io_rd[i]) rdata = rdata | DATA_W'(bank_flat[i*BANK_W +: BANK_W]);
        end
    end

    assign hit = |io_rd;
endmodule

// File: rtl/bwm_top.sv
// Module: bwm_top
// Banked memory window mapper: two CPU windows, each with a writable frame
// latch in I/O space, mapped onto separate halves of a 1 MB external SRAM.
// Assumes NUM_WIN >= 2 and DATA_W >= BANK_W; synchronous active-low reset.
module bwm_top #(
    parameter int                      CPU_AW    = bwm_pkg::CPU_AW,
    parameter int                      DATA_W    = bwm_pkg::DATA_W,
    parameter int                      BANK_W    = bwm_pkg::BANK_W,
    parameter int                      OFS_W     = bwm_pkg::OFS_W,
    parameter int                      NUM_WIN   = bwm_pkg::NUM_WIN,
    parameter logic [CPU_AW-1:0]       IO_BASE   = bwm_pkg::IO_BASE,
    parameter logic [CPU_AW-OFS_W-1:0] WIN_PAGE0 = bwm_pkg::WIN_PAGE0,
    parameter int                      PHYS_W    = $clog2(NUM_WIN) + BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rnw,
    input  logic              cpu_vma,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_hit,
    output logic [PHYS_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_hit
);
    localparam int SEL_W = PHYS_W - BANK_W - OFS_W;

    logic [NUM_WIN-1:0]        win_hit;
    logic [SEL_W-1:0]          win_idx;
    logic [NUM_WIN-1:0]        io_wr;
    logic [NUM_WIN-1:0]        io_rd;
    logic [NUM_WIN*BANK_W-1:0] bank_flat;

    bwm_decode #(
        .CPU_AW(CPU_AW), .OFS_W(OFS_W), .NUM_WIN(NUM_WIN), .SEL_W(SEL_W),
        .IO_BASE(IO_BASE), .WIN_PAGE0(WIN_PAGE0)
    ) u_dec (
        .addr(cpu_addr), .rnw(cpu_rnw), .vma(cpu_vma),
        .win_hit(win_hit), .win_idx(win_idx), .io_wr(io_wr), .io_rd(io_rd)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_bank
        bwm_bank_latch #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_latch (
            .clk(clk), .rst_n(rst_n), .wr_en(io_wr[i]), .wdata(cpu_wdata),
            .q(bank_flat[i*BANK_W +: BANK_W])
        );
    end

    bwm_compose #(
        .NUM_WIN(NUM_WIN), .SEL_W(SEL_W), .BANK_W(BANK_W),
        .OFS_W(OFS_W), .PHYS_W(PHYS_W)
    ) u_cmp (
        .win_hit(win_hit), .win_idx(win_idx), .bank_flat(bank_flat),
        .offset(cpu_addr[OFS_W-1:0]), .rnw(cpu_rnw),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_hit(sram_hit)
    );

    bwm_readback #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_rb (
        .io_rd(io_rd), .bank_flat(bank_flat), .rdata(reg_rdata), .hit(reg_hit)
    );
endmodule

// File: rtl/bwm_checker.sv
// Module: bwm_checker
// Property checks for bwm_top, attached with bind. Observes ports plus the
// flattened bank latch vector. Assumes inputs are settled at each rising edge.
module bwm_checker #(
    parameter int                      CPU_AW    = bwm_pkg::CPU_AW,
    parameter int                      DATA_W    = bwm_pkg::DATA_W,
    parameter int                      BANK_W    = bwm_pkg::BANK_W,
    parameter int                      OFS_W     = bwm_pkg::OFS_W,
    parameter int                      NUM_WIN   = bwm_pkg::NUM_WIN,
    parameter logic [CPU_AW-1:0]       IO_BASE   = bwm_pkg::IO_BASE,
    parameter logic [CPU_AW-OFS_W-1:0] WIN_PAGE0 = bwm_pkg::WIN_PAGE0,
    parameter int                      PHYS_W    = $clog2(NUM_WIN) + BANK_W + OFS_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CPU_AW-1:0]         cpu_addr,
    input logic                      cpu_rnw,
    input logic                      cpu_vma,
    input logic [DATA_W-1:0]         cpu_wdata,
    input logic [DATA_W-1:0]         reg_rdata,
    input logic                      reg_hit,
    input logic [PHYS_W-1:0]         sram_addr,
    input logic                      sram_ce_n,
    input logic                      sram_hit,
    input logic [NUM_WIN*BANK_W-1:0] bank_flat
);
    localparam int SEL_W  = PHYS_W - BANK_W - OFS_W;
    localparam int PAGE_W = CPU_AW - OFS_W;

    logic [PAGE_W-1:0] page;
    logic              outside;
    assign page    = cpu_addr[CPU_AW-1:OFS_W];
    assign outside = (int'(page) < int'(WIN_PAGE0)) || (int'(page) >= int'(WIN_PAGE0) + NUM_WIN);

    // R1: latches are clear on the first cycle after reset release
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_flat == '0));

    // R6, R7: no chip enable and a zero address outside the windows or without VMA
    p_ce_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_vma || outside) |-> (sram_ce_n && sram_addr == '0 && !sram_hit));

    // R7: SRAM read select only on reads
    p_hit_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_hit |-> (cpu_rnw && !sram_ce_n));

    // R5: read-back is zero when not selected, upper bits always zero
    p_rdata_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_hit |-> (reg_rdata == '0));
    p_rdata_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |-> (reg_rdata[DATA_W-1:BANK_W] == '0));

    // R5, R6: the two read-mux selects never overlap
    p_sel_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_hit && sram_hit));

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
        localparam logic [PAGE_W-1:0] PG   = WIN_PAGE0 + PAGE_W'(i);
        localparam logic [CPU_AW-1:0] IO_A = IO_BASE + CPU_AW'(i);

        // R2, R3: address composition for window i
        p_addr_compose_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_vma && page == PG) |->
            (!sram_ce_n && sram_addr == {SEL_W'(i), bank_flat[i*BANK_W +: BANK_W], cpu_addr[OFS_W-1:0]}));

        // R4: qualified write loads the low data bits
        p_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_vma && !cpu_rnw && cpu_addr == IO_A) |=>
            (bank_flat[i*BANK_W +: BANK_W] == $past(cpu_wdata[BANK_W-1:0])));

        // R8: latch holds without a qualified write to its address
        p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(cpu_vma && !cpu_rnw && cpu_addr == IO_A) |=>
            $stable(bank_flat[i*BANK_W +: BANK_W]));
    end
endmodule

bind bwm_top bwm_checker #(
    .CPU_AW(CPU_AW), .DATA_W(DATA_W), .BANK_W(BANK_W), .OFS_W(OFS_W),
    .NUM_WIN(NUM_WIN), .IO_BASE(IO_BASE), .WIN_PAGE0(WIN_PAGE0), .PHYS_W(PHYS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
    .cpu_vma(cpu_vma), .cpu_wdata(cpu_wdata), .reg_rdata(reg_rdata),
    .reg_hit(reg_hit), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_hit(sram_hit), .bank_flat(bank_flat)
);

// File: tb/sim_bwm_top.sv
// Directed bench for bwm_top with a small behavioural SRAM model.
module sim_bwm_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rnw = 1'b1;
    logic        cpu_vma = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        reg_hit;
    logic [19:0] sram_addr;
    logic        sram_ce_n;
    logic        sram_hit;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    bwm_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
        .cpu_vma(cpu_vma), .cpu_wdata(cpu_wdata), .reg_rdata(reg_rdata),
        .reg_hit(reg_hit), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_hit(sram_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // SRAM model: 128 frames x 4 sampled offsets (0x0000, 0x0001, 0x1FFE, 0x1FFF)
    logic [7:0] mem [512];
    logic [8:0] midx;
    assign midx = {sram_addr[19:13], sram_addr[12], sram_addr[0]};
    initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    always @(posedge clk) if (rst_n && !sram_ce_n && !cpu_rnw) mem[midx] <= cpu_wdata;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One CPU cycle: drive on the falling edge, settle before sampling
    task automatic cyc(input logic [15:0] a, input logic rnw, input logic vma, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rnw = rnw; cpu_vma = vma; cpu_wdata = d;
        #2;
    endtask

    task automatic idle();
        cyc(16'h0000, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic set_bank(input int w, input logic [7:0] d);
        cyc(16'hFC30 + 16'(w), 1'b0, 1'b1, d);
    endtask

    task automatic read_bank(input int w, input string req, input logic [7:0] exp);
        cyc(16'hFC30 + 16'(w), 1'b1, 1'b1, 8'h00);
        check(req, "reg_hit", 32'(reg_hit), 32'd1);
        check(req, "reg_rdata", 32'(reg_rdata), 32'(exp));
    endtask

    task automatic t_reset();
        read_bank(0, "R1", 8'h00);
        read_bank(1, "R1", 8'h00);
        cyc(16'hA000, 1'b1, 1'b1, 8'h00);
        check("R1", "addr after reset", 32'(sram_addr), 32'h00000);
    endtask

    task automatic t_window_low();
        set_bank(0, 8'h2A);
        cyc(16'hA123, 1'b1, 1'b1, 8'h00);
        check("R2", "addr A123", 32'(sram_addr), 32'({1'b0, 6'h2A, 13'h0123}));
        check("R2", "ce_n", 32'(sram_ce_n), 32'd0);
        check("R7", "sram_hit read", 32'(sram_hit), 32'd1);
        cyc(16'hBFFF, 1'b1, 1'b1, 8'h00);
        check("R2", "addr BFFF", 32'(sram_addr), 32'({1'b0, 6'h2A, 13'h1FFF}));
    endtask

    task automatic t_window_high();
        set_bank(1, 8'h15);
        cyc(16'hC000, 1'b1, 1'b1, 8'h00);
        check("R3", "addr C000", 32'(sram_addr), 32'({1'b1, 6'h15, 13'h0000}));
        cyc(16'hDFFF, 1'b1, 1'b1, 8'h00);
        check("R3", "addr DFFF", 32'(sram_addr), 32'({1'b1, 6'h15, 13'h1FFF}));
        cyc(16'hA000, 1'b1, 1'b1, 8'h00);
        check("R3", "low window keeps own latch", 32'(sram_addr), 32'({1'b0, 6'h2A, 13'h0000}));
    endtask

    task automatic t_latch_write();
        set_bank(0, 8'hFF);
        read_bank(0, "R4", 8'h3F);
        read_bank(1, "R4", 8'h15);
        set_bank(1, 8'hC7);
        cyc(16'hC001, 1'b1, 1'b1, 8'h00);
        check("R4", "new bank next cycle", 32'(sram_addr), 32'({1'b1, 6'h07, 13'h0001}));
    endtask

    task automatic t_readback();
        cyc(16'hFC30, 1'b1, 1'b0, 8'h00);
        check("R5", "hit without vma", 32'(reg_hit), 32'd0);
        check("R5", "data without vma", 32'(reg_rdata), 32'd0);
        cyc(16'hFC32, 1'b1, 1'b1, 8'h00);
        check("R5", "hit at FC32", 32'(reg_hit), 32'd0);
        cyc(16'hFC30, 1'b0, 1'b1, 8'h3F);
        check("R5", "hit on write", 32'(reg_hit), 32'd0);
    endtask

    task automatic t_ignored();
        set_bank(0, 8'h3F);
        cyc(16'hFC30, 1'b0, 1'b0, 8'h11);
        cyc(16'hFC30, 1'b1, 1'b1, 8'h12);
        cyc(16'hFC2F, 1'b0, 1'b1, 8'h13);
        cyc(16'hFC32, 1'b0, 1'b1, 8'h14);
        read_bank(0, "R8", 8'h3F);
        read_bank(1, "R8", 8'h07);
    endtask

    task automatic t_chip_enable();
        cyc(16'h9FFF, 1'b1, 1'b1, 8'h00);
        check("R6", "ce_n 9FFF", 32'(sram_ce_n), 32'd1);
        check("R7", "addr zero 9FFF", 32'(sram_addr), 32'd0);
        cyc(16'hE000, 1'b1, 1'b1, 8'h00);
        check("R6", "ce_n E000", 32'(sram_ce_n), 32'd1);
        cyc(16'hFC30, 1'b1, 1'b1, 8'h00);
        check("R6", "ce_n FC30", 32'(sram_ce_n), 32'd1);
        cyc(16'hB000, 1'b1, 1'b0, 8'h00);
        check("R6", "ce_n no vma", 32'(sram_ce_n), 32'd1);
        check("R7", "hit no vma", 32'(sram_hit), 32'd0);
        cyc(16'hD000, 1'b0, 1'b1, 8'h00);
        check("R6", "ce_n write", 32'(sram_ce_n), 32'd0);
        check("R7", "hit on write", 32'(sram_hit), 32'd0);
        idle();
    endtask

    function automatic logic [7:0] pat(input int w, input int b, input int k);
        return 8'(b*4 + k) ^ ((w != 0) ? 8'hA5 : 8'h00);
    endfunction

    function automatic logic [15:0] ofs_addr(input int w, input int k);
        logic [15:0] base;
        base = (w == 0) ? 16'hA000 : 16'hC000;
        case (k)
            0: return base;
            1: return base + 16'h0001;
            2: return base + 16'h1FFE;
            default: return base + 16'h1FFF;
        endcase
    endfunction

    // R9: ramp into every frame of both windows, then read back per frame
    task automatic t_ramp();
        for (int b = 0; b < 64; b++) begin
            set_bank(0, 8'(b));
            set_bank(1, 8'(b));
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 4; k++)
                    cyc(ofs_addr(w, k), 1'b0, 1'b1, pat(w, b, k));
        end
        for (int b = 0; b < 64; b++) begin
            set_bank(0, 8'(b));
            set_bank(1, 8'(b));
            for (int w = 0; w < 2; w++) begin
                logic [31:0] bad;
                bad = 0;
                for (int k = 0; k < 4; k++) begin
                    cyc(ofs_addr(w, k), 1'b1, 1'b1, 8'h00);
                    if (sram_ce_n || mem[midx] !== pat(w, b, k)) bad++;
                end
                check("R9", $sformatf("frame w%0d b%0d bad bytes", w, b), bad, 32'd0);
            end
        end
        idle();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window_low();
        t_window_high();
        t_latch_write();
        t_readback();
        t_ignored();
        t_chip_enable();
        t_ramp();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule